// File: doc/BRIEF.md
# Multi-Lane Serial Flash Physical Layer

This block moves words between a stream interface and a serial flash at single data rate. It runs over one, two, four or eight data lanes. Each word that enters carries four things: its payload, a bit length, a lane-width code and a per-lane output-enable mask. The block shifts the payload out most significant bit first. It captures the same number of bits from the data inputs and returns the captured bits as one word on its source stream.

A flash command is sent as a series of words: opcode, address, dummy and data. A dummy phase is a word whose output-enable mask is zero and whose bit length is the dummy bit count. Its clock cycle count is therefore the bit count divided by the lane width of that word. The serial clock is divided from the system clock by a run-time divisor. Chip select stays low from the first word to the word flagged last. After that, chip select stays high for a programmable minimum gap before a new command is accepted.

Top module: `spi_flash_phy`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, all output enables are low, `sink_ready` is high and `src_valid` is low.
- R2: While a word shifts, each serial clock period lasts 2*(clk_div+1) system cycles, so a divisor of 0 gives half the system clock. The divisor may change between commands.
- R3: Width code 0/1/2/3 selects 1/2/4/8 lanes. The low `sink_len` bits of `sink_data` leave most significant bit first, and within a group the higher-numbered lane carries the more significant bit.
- R4: On each rising serial clock edge the block samples as many bits as there are active lanes, with the higher lane more significant. `src_data` holds the word's `sink_len` received bits right-aligned.
- R5: With width code 0 the block drives lane 0 only and samples lane 1, even when more lanes are wired.
- R6: A word of L bits at width W produces exactly L/W rising serial clock edges. A dummy word (mask zero) of 8 bits at 4 lanes gives 2 edges.
- R7: While a word shifts, `dq_oe` equals the word's mask restricted to the active lanes. While chip select is high, `dq_oe` is all zero.
- R8: Chip select falls before the first rising serial clock edge and stays low between words of one command. It rises when the last word completes. It then stays high, with `sink_ready` low, for at least cs_gap+1 system cycles.
- R9: The serial clock is low while chip select is high, and `dq_o` changes only while the serial clock is low.
- R10: Each completed word raises `src_valid` for exactly one system cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sink_valid | input | 1 | A word is offered |
| sink_ready | output | 1 | The block can take a word |
| sink_data | input | DW | Payload, right-aligned |
| sink_len | input | LEN_W | Number of bits in the word |
| sink_width | input | 2 | Lane-width code (0:1, 1:2, 2:4, 3:8 lanes) |
| sink_oe_mask | input | LANES | Lanes driven during this word |
| sink_last | input | 1 | Word ends the command |
| src_valid | output | 1 | Received word valid (one-cycle pulse) |
| src_data | output | DW | Received bits, right-aligned |
| clk_div | input | DIV_W | Serial clock divisor |
| cs_gap | input | GAP_W | Minimum chip-select high time, in system cycles minus one |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_clk | output | 1 | Serial clock |
| dq_o | output | LANES | Data lane outputs |
| dq_oe | output | LANES | Data lane output enables |
| dq_i | input | LANES | Data lane inputs |

## Verification
The hardest case to show from the ports is single-lane capture on a bus built for four lanes. Lane 0 carries the block's own outgoing bit, so a design that samples lane 0 can still look plausible. The bench's flash model drives the response on lane 1 and the complement of that response on lane 0, so any capture from the wrong lane corrupts every bit. The sweep covers every pairing of address width and read width, and each pairing runs at several divisors. This exercises dummy words whose clock count shrinks with lane width, and it times every serial clock period against the divisor in force.

// File: rtl/spi_flash_phy_pkg.sv
package spi_flash_phy_pkg;

  // Lane-width codes carried with each word
  localparam logic [1:0] WC_X1 = 2'd0;
  localparam logic [1:0] WC_X2 = 2'd1;
  localparam logic [1:0] WC_X4 = 2'd2;
  localparam logic [1:0] WC_X8 = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2,
    ST_GAP   = 2'd3
  } phy_state_e;

endpackage

// File: rtl/spi_flash_phy_clkdiv.sv
module spi_flash_phy_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  // One tick per half serial period: div+1 system cycles
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q >= div) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q >= div);

endmodule

// File: rtl/spi_flash_phy_txmap.sv
module spi_flash_phy_txmap #(
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic [DW-1:0]    shreg,
  input  logic [1:0]       wcode,
  input  logic             active,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] dq_o,
  output logic [LANES-1:0] dq_oe
);

  // Top w bits of the shift register go out, lane w-1 taking the MSB
  always_comb begin
    int w;
    w     = 1 << wcode;
    dq_o  = '0;
    dq_oe = '0;
    for (int l = 0; l < LANES; l++) begin
      if (l < w) begin
        dq_o[l]  = shreg[DW - w + l];
        dq_oe[l] = active && mask[l];
      end
    end
  end

endmodule

// File: rtl/spi_flash_phy_rxshift.sv
module spi_flash_phy_rxshift
  import spi_flash_phy_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             sample,
  input  logic [1:0]       wcode,
  input  logic [LANES-1:0] dq_i,
  output logic [DW-1:0]    word
);

  localparam int PAD = 8;

  logic [PAD-1:0] din;

  for (genvar i = 0; i < PAD; i++) begin : g_pad
    if (i < LANES) begin : g_wired
      assign din[i] = dq_i[i];
    end else begin : g_absent
      assign din[i] = 1'b0;
    end
  end

  // Single-lane capture listens on lane 1 (lane 0 is the outgoing line)
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      word <= '0;
    end else if (sample) begin
      case (wcode)
        WC_X1:   word <= {word[DW-2:0], din[1]};
        WC_X2:   word <= {word[DW-3:0], din[1:0]};
        WC_X4:   word <= {word[DW-5:0], din[3:0]};
        default: word <= {word[DW-9:0], din[7:0]};
      endcase
    end
  end

endmodule

// File: rtl/spi_flash_phy.sv
module spi_flash_phy
  import spi_flash_phy_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LANES = 4,
  parameter int DIV_W = 8,
  parameter int GAP_W = 4,
  parameter int LEN_W = $clog2(DW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sink_valid,
  output logic             sink_ready,
  input  logic [DW-1:0]    sink_data,
  input  logic [LEN_W-1:0] sink_len,
  input  logic [1:0]       sink_width,
  input  logic [LANES-1:0] sink_oe_mask,
  input  logic             sink_last,
  output logic             src_valid,
  output logic [DW-1:0]    src_data,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [GAP_W-1:0] cs_gap,
  output logic             spi_cs_n,
  output logic             spi_clk,
  output logic [LANES-1:0] dq_o,
  output logic [LANES-1:0] dq_oe,
  input  logic [LANES-1:0] dq_i
);

  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DW);

  phy_state_e       st_q;
  logic [DW-1:0]    shreg_q;
  logic [LEN_W-1:0] bits_left_q;
  logic [1:0]       wcode_q;
  logic [LANES-1:0] mask_q;
  logic             last_q;
  logic             cs_n_q;
  logic             sclk_q;
  logic             src_valid_q;
  logic [GAP_W-1:0] gap_cnt_q;

  logic             tick;
  logic             rise;
  logic             fall;
  logic             accept;
  logic [LEN_W-1:0] step;

  assign sink_ready = (st_q == ST_IDLE) || (st_q == ST_HOLD);
  assign accept     = sink_valid && sink_ready;
  assign rise       = tick && !sclk_q;
  assign fall       = tick && sclk_q;
  assign step       = LEN_W'(1) << wcode_q;

  spi_flash_phy_clkdiv #(.DIV_W(DIV_W)) i_div (
    .clk  (clk),
    .rst  (rst),
    .run  (st_q == ST_SHIFT),
    .div  (clk_div),
    .tick (tick)
  );

  spi_flash_phy_txmap #(.DW(DW), .LANES(LANES)) i_tx (
    .shreg  (shreg_q),
    .wcode  (wcode_q),
    .active (st_q == ST_SHIFT),
    .mask   (mask_q),
    .dq_o   (dq_o),
    .dq_oe  (dq_oe)
  );

  spi_flash_phy_rxshift #(.DW(DW), .LANES(LANES)) i_rx (
    .clk    (clk),
    .rst    (rst),
    .clr    (accept),
    .sample (rise),
    .wcode  (wcode_q),
    .dq_i   (dq_i),
    .word   (src_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      shreg_q     <= '0;
      bits_left_q <= '0;
      wcode_q     <= WC_X1;
      mask_q      <= '0;
      last_q      <= 1'b0;
      cs_n_q      <= 1'b1;
      sclk_q      <= 1'b0;
      src_valid_q <= 1'b0;
      gap_cnt_q   <= '0;
    end else begin
      src_valid_q <= 1'b0;
      case (st_q)
        ST_IDLE, ST_HOLD: begin
          if (accept) begin
            shreg_q     <= sink_data << (FULL_LEN - sink_len);
            bits_left_q <= sink_len;
            wcode_q     <= sink_width;
            mask_q      <= sink_oe_mask;
            last_q      <= sink_last;
            cs_n_q      <= 1'b0;
            st_q        <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (rise) begin
            sclk_q      <= 1'b1;
            bits_left_q <= (bits_left_q > step) ? bits_left_q - step : '0;
          end else if (fall) begin
            sclk_q <= 1'b0;
            if (bits_left_q == '0) begin
              src_valid_q <= 1'b1;
              if (last_q) begin
                cs_n_q    <= 1'b1;
                gap_cnt_q <= cs_gap;
                st_q      <= ST_GAP;
              end else begin
                st_q <= ST_HOLD;
              end
            end else begin
              shreg_q <= shreg_q << step;
            end
          end
        end
        default: begin
          if (gap_cnt_q == '0) begin
            st_q <= ST_IDLE;
          end else begin
            gap_cnt_q <= gap_cnt_q - 1'b1;
          end
        end
      endcase
    end
  end

  assign spi_cs_n  = cs_n_q;
  assign spi_clk   = sclk_q;
  assign src_valid = src_valid_q;

endmodule

// File: rtl/spi_flash_phy_chk.sv
module spi_flash_phy_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             spi_cs_n,
  input logic             spi_clk,
  input logic [LANES-1:0] dq_o,
  input logic [LANES-1:0] dq_oe,
  input logic             sink_ready,
  input logic             src_valid,
  input logic [1:0]       wcode
);

  // R9
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_clk);

  // R7
  oe_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> (dq_oe == '0));

  // R3
  oe_lane_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(dq_oe) <= (32'd1 << wcode));

  // R9
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    spi_clk |-> $stable(dq_o));

  // R10
  src_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    src_valid |=> !src_valid);

  // R8
  gap_block_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> !sink_ready);

  // R8
  cs_before_clk_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> !spi_clk);

endmodule

bind spi_flash_phy spi_flash_phy_chk #(.LANES(LANES)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .spi_cs_n   (spi_cs_n),
  .spi_clk    (spi_clk),
  .dq_o       (dq_o),
  .dq_oe      (dq_oe),
  .sink_ready (sink_ready),
  .src_valid  (src_valid),
  .wcode      (wcode_q)
);

// File: tb/test_spi_flash_phy.sv
`timescale 1ns/100ps
module test_spi_flash_phy;

  localparam int DW    = 32;
  localparam int LANES = 4;
  localparam int DIV_W = 8;
  localparam int GAP_W = 4;
  localparam int LEN_W = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sink_valid = 1'b0;
  logic             sink_ready;
  logic [DW-1:0]    sink_data = '0;
  logic [LEN_W-1:0] sink_len = '0;
  logic [1:0]       sink_width = '0;
  logic [LANES-1:0] sink_oe_mask = '0;
  logic             sink_last = 1'b0;
  logic             src_valid;
  logic [DW-1:0]    src_data;
  logic [DIV_W-1:0] clk_div = '0;
  logic [GAP_W-1:0] cs_gap = '0;
  logic             spi_cs_n;
  logic             spi_clk;
  logic [LANES-1:0] dq_o;
  logic [LANES-1:0] dq_oe;
  logic [LANES-1:0] dq_i;

  always #2.5 clk = ~clk;

  spi_flash_phy #(.DW(DW), .LANES(LANES), .DIV_W(DIV_W), .GAP_W(GAP_W), .LEN_W(LEN_W)) i_spi_flash_phy (
    .clk(clk), .rst(rst), .sink_valid(sink_valid), .sink_ready(sink_ready),
    .sink_data(sink_data), .sink_len(sink_len), .sink_width(sink_width),
    .sink_oe_mask(sink_oe_mask), .sink_last(sink_last), .src_valid(src_valid),
    .src_data(src_data), .clk_div(clk_div), .cs_gap(cs_gap), .spi_cs_n(spi_cs_n),
    .spi_clk(spi_clk), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] code);
    int w = 1 << code;
    return LANES'((32'd1 << w) - 1);
  endfunction

  // Flash model state
  logic [31:0]      resp_l = '0;
  int               ridx = 0;
  logic [1:0]       mcode = 2'd0;
  logic [31:0]      mosi = '0;
  int               edges = 0;
  logic [LANES-1:0] exp_oe = '0;
  bit               oe_bad = 0, cs_bad = 0, per_bad = 0;
  realtime          last_rise = 0;
  int               cur_div = 0;
  int               hi_run = 0, last_hi = 0;

  // Response bits, MSB first; single lane answers on lane 1, lane 0 carries the complement
  always_comb begin
    int w;
    int pos;
    logic b;
    dq_i = '0;
    w = 1 << mcode;
    if (mcode == 2'd0) begin
      pos = 31 - ridx;
      b = (pos >= 0) ? resp_l[pos] : 1'b0;
      dq_i[1] = b;
      dq_i[0] = ~b;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (l < w) begin
          pos = 31 - ridx * w - (w - 1 - l);
          dq_i[l] = (pos >= 0) ? resp_l[pos] : 1'b0;
        end
      end
    end
  end

  always @(posedge spi_clk) begin
    if (spi_cs_n) cs_bad = 1;
    if (dq_oe !== exp_oe) oe_bad = 1;
    if (edges > 0 && ($realtime - last_rise) != 10.0 * (cur_div + 1)) per_bad = 1;
    last_rise = $realtime;
    mosi = (mosi << (1 << mcode)) | 32'(dq_o & lane_mask(mcode));
    edges++;
    ridx++;
  end

  always @(posedge clk) begin
    cyc++;
    if (rst) hi_run = 0;
    else if (spi_cs_n) hi_run++;
    else begin
      if (hi_run > 0) last_hi = hi_run;
      hi_run = 0;
    end
    if (cyc == 180000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic xfer(input logic [31:0] data, input int len, input logic [1:0] code,
                      input logic [LANES-1:0] mask, input bit last, input logic [31:0] resp);
    int w = 1 << code;
    int n = 0;
    logic [31:0] lm = (len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
    @(negedge clk);
    while (!sink_ready && n < 5000) begin @(negedge clk); n++; end
    resp_l = resp << (32 - len);
    ridx = 0; mcode = code; mosi = '0; edges = 0;
    exp_oe = mask & lane_mask(code);
    oe_bad = 0; cs_bad = 0; per_bad = 0;
    sink_data = data; sink_len = LEN_W'(len); sink_width = code;
    sink_oe_mask = mask; sink_last = last; sink_valid = 1'b1;
    @(posedge clk);
    #1 sink_valid = 1'b0;
    n = 0;
    while (!src_valid && n < 5000) begin @(negedge clk); n++; end
    chk(src_valid, "R10 word completes", {31'd0, src_valid}, 32'd1);
    if (code == 2'd0) chk(src_data == (resp & lm), "R5 single-lane capture", src_data, resp & lm);
    else chk(src_data == (resp & lm), "R4 multi-lane capture", src_data, resp & lm);
    chk(edges == len / w, "R6 edge count", 32'(edges), 32'(len / w));
    if (mask != '0) chk(mosi == (data & lm), "R3 output bit order", mosi, data & lm);
    chk(!oe_bad, "R7 output enable", {28'd0, dq_oe}, {28'd0, exp_oe});
    chk(!per_bad, "R2 clock period", 32'(cur_div), 32'(cur_div));
    chk(!cs_bad, "R8 select before edge", 32'(cs_bad), 32'd0);
    if (last) chk(spi_cs_n && !sink_ready, "R8 release on last", {30'd0, spi_cs_n, sink_ready}, 32'd2);
    else chk(!spi_cs_n, "R8 held between words", {31'd0, spi_cs_n}, 32'd0);
    @(negedge clk);
    chk(!src_valid, "R10 one-cycle pulse", {31'd0, src_valid}, 32'd0);
  endtask

  initial begin
    int prev_gap = 0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(spi_cs_n && !spi_clk && dq_oe == '0 && sink_ready && !src_valid, "R1 reset state",
        {27'd0, spi_cs_n, spi_clk, |dq_oe, sink_ready, src_valid}, 32'b10010);
    for (int d = 0; d < 3; d++) begin
      for (int ac = 0; ac < 3; ac++) begin
        for (int rc = 0; rc < 3; rc++) begin
          @(negedge clk);
          clk_div = DIV_W'(d);
          cur_div = d;
          cs_gap  = GAP_W'(d * 3 + rc);
          xfer(32'h6B ^ 32'(d * 16 + ac * 4 + rc), 8, 2'd0, 4'b0001, 1'b0, 32'h5A);
          chk(last_hi >= prev_gap + 1, "R8 minimum gap", 32'(last_hi), 32'(prev_gap + 1));
          xfer(32'h00C3_5A96 + 32'(ac * 257), 24, 2'(ac), lane_mask(2'(ac)), 1'b0, 32'h00F0_0F3C);
          xfer(32'h0, 8, 2'(ac), 4'b0000, 1'b0, 32'h00);
          xfer(32'h0, 32, 2'(rc), 4'b0000, 1'b1, 32'h8421_E7B3 ^ 32'(d * 65536 + ac * 256 + rc * 7));
          prev_gap = d * 3 + rc;
        end
      end
    end
    repeat (20) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule